// File: doc/BRIEF.md
# Serial Register Target with Consistent Time Snapshot

This block is a two-wire serial bus target that gives a bus host byte access to a small register space. The block samples the clock and data lines with a fast system clock and detects the start and stop conditions. It checks the 7-bit device address. After the address, a register pointer selects the register, and this pointer moves up by one after each byte.

Writes are not stored in the block. Each byte written appears as a single-cycle strobe with its address and data, for the register store that sits next to the block. Reads take their data from a flat input bus that carries the current contents of every register. The lowest registers hold live counter values. For these, reads come from a shadow copy, so a multibyte read sees one consistent moment. The shadow is reloaded on every start, on every stop, and when the pointer wraps to zero.

Top module: `i2c_reg_target`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal 1101000 (bit 0 is the direction: 0 write, 1 read). Otherwise it leaves SDA released, acknowledges nothing and emits no write strobe until the next start or stop.
- R2: In a write transfer, the first byte after the address loads the pointer from its low four bits. Each later byte is acknowledged and emitted on `wr_stb_o`/`wr_addr_o`/`wr_data_o` at its acknowledge clock, and the pointer then steps by one.
- R3: The pointer wraps from address 15 to address 0, both when writing and when reading.
- R4: In a read transfer, the block sends the register at the pointer MSB first and then steps the pointer. A host acknowledge (SDA low on the ninth clock) asks for the next byte.
- R5: A read that is not preceded by a pointer write starts at the address the pointer holds from earlier transfers.
- R6: Reads of addresses 0 to `NTIME-1` return a snapshot of `live_regs_i`. The snapshot is taken at each start, at each stop and when the pointer steps to 0. Changes made to the live values between two snapshots are not seen.
- R7: When the host does not acknowledge a read byte, the block releases SDA and stays silent until the next start or stop.
- R8: A repeated start ends the current transfer and begins a new address phase, with the pointer kept.
- R9: SDA is driven only low, through `sda_oe_o`. After reset and while idle, `sda_oe_o` and `wr_stb_o` are 0.
- R10: `sda_oe_o` changes only while SCL is low, so the block itself never creates a start or stop condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous-style reset, sampled on clk |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| live_regs_i | input | NREG*8 | Current contents of all registers, register n in bits [8n+7:8n] |
| wr_stb_o | output | 1 | One-cycle strobe for a written byte |
| wr_addr_o | output | log2(NREG) | Register address of the written byte |
| wr_data_o | output | 8 | Written byte |

## Verification
The assertions assume a host that follows the bus rules. SDA moves only while SCL is low, except when the host makes a start or stop condition. Every SCL phase is also several system clocks long, so the synchronized edges come one at a time. The bench drives SCL and SDA from the falling clock edge. It holds each quarter bit for ten system clocks, and it always ends a read with a non-acknowledge before the stop, so the block is never driving SDA when the stop arrives.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;
   localparam int BYTE_W = 8;
   typedef enum logic [2:0] {
      PS_IDLE,
      PS_ADDR,
      PS_PTR,
      PS_WDATA,
      PS_RDATA,
      PS_IGNORE
   } phase_e;
endpackage

// File: rtl/i2cr_bus_front.sv
module i2cr_bus_front #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_lvl,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [1:0] raw;
   logic [1:0] lvl;
   logic [1:0] lvl_q;

   assign raw = {scl_i, sda_i};

   for (genvar g = 0; g < 2; g++) begin : g_line
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk) begin
         if (!rst_n) chain <= '1;
         else        chain <= {chain[SYNC_STAGES-2:0], raw[g]};
      end
      assign lvl[g] = chain[SYNC_STAGES-1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) lvl_q <= '1;
      else        lvl_q <= lvl;
   end

   assign scl_lvl   = lvl[1];
   assign sda_lvl   = lvl[0];
   assign scl_rise  = lvl[1] & ~lvl_q[1];
   assign scl_fall  = ~lvl[1] & lvl_q[1];
   assign start_det = lvl[1] & lvl_q[1] & lvl_q[0] & ~lvl[0];
   assign stop_det  = lvl[1] & lvl_q[1] & ~lvl_q[0] & lvl[0];
endmodule

// File: rtl/i2cr_readmux.sv
module i2cr_readmux #(
   parameter int NREG  = 16,
   parameter int NTIME = 7
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    snap,
   input  logic [NREG*8-1:0]       live_i,
   input  logic [$clog2(NREG)-1:0] rd_addr,
   output logic [7:0]              rd_data
);
   if (NTIME > 0) begin : g_shadow
      logic [NTIME*8-1:0] shadow;
      logic [NREG*8-1:0]  shadow_ext;

      always_ff @(posedge clk) begin
         if (!rst_n)    shadow <= '0;
         else if (snap) shadow <= live_i[NTIME*8-1:0];
      end

      assign shadow_ext = {{((NREG-NTIME)*8){1'b0}}, shadow};

      always_comb begin
         if (int'(rd_addr) < NTIME && !snap) rd_data = shadow_ext[rd_addr*8 +: 8];
         else                                rd_data = live_i[rd_addr*8 +: 8];
      end

      // R6
      snap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
         snap |=> shadow == $past(live_i[NTIME*8-1:0]));
   end else begin : g_live_only
      assign rd_data = live_i[rd_addr*8 +: 8];
   end
endmodule

// File: rtl/i2cr_proto.sv
module i2cr_proto
   import i2cr_pkg::*;
#(
   parameter int          AW       = 4,
   parameter logic [6:0]  DEV_ADDR = 7'h68
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_lvl,
   input  logic              sda_lvl,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic [BYTE_W-1:0] rd_data,
   output logic [AW-1:0]     rd_addr,
   output logic              snap,
   output logic              sda_oe,
   output logic              wr_stb,
   output logic [AW-1:0]     wr_addr,
   output logic [BYTE_W-1:0] wr_data
);
   phase_e            st;
   logic [3:0]        bitcnt;
   logic [BYTE_W-1:0] rx, tx;
   logic              in_ack, rw, host_ack;
   logic [AW-1:0]     ptr, ptr_nx;
   logic              adv, active;

   assign ptr_nx  = ptr + 1'b1;
   assign active  = (st != PS_IDLE) && (st != PS_IGNORE) && !start_det && !stop_det;
   assign adv     = active && scl_fall &&
                    ((!in_ack && bitcnt == 4'd8 && st == PS_WDATA) ||
                     (in_ack && st == PS_RDATA));
   assign snap    = start_det | stop_det | (adv && ptr_nx == '0);
   assign rd_addr = (in_ack && st == PS_RDATA) ? ptr_nx : ptr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= PS_IDLE;  bitcnt <= '0;  rx <= '0;  tx <= '0;
         in_ack <= 1'b0; rw <= 1'b0;    host_ack <= 1'b0;
         ptr <= '0;      sda_oe <= 1'b0;
         wr_stb <= 1'b0; wr_addr <= '0; wr_data <= '0;
      end else begin
         wr_stb <= 1'b0;
         if (start_det || stop_det) begin
            st     <= start_det ? PS_ADDR : PS_IDLE;
            bitcnt <= '0;
            in_ack <= 1'b0;
            sda_oe <= 1'b0;
         end else if (active) begin
            if (scl_rise) begin
               if (!in_ack) begin
                  rx     <= {rx[BYTE_W-2:0], sda_lvl};
                  bitcnt <= bitcnt + 1'b1;
               end else begin
                  host_ack <= !sda_lvl;
               end
            end else if (scl_fall) begin
               if (!in_ack && bitcnt == 4'd8) begin
                  in_ack <= 1'b1;
                  case (st)
                     PS_ADDR:
                        if (rx[7:1] == DEV_ADDR) begin
                           sda_oe <= 1'b1;
                           rw     <= rx[0];
                        end else begin
                           st <= PS_IGNORE;
                        end
                     PS_PTR: begin
                        sda_oe <= 1'b1;
                        ptr    <= rx[AW-1:0];
                     end
                     PS_WDATA: begin
                        sda_oe  <= 1'b1;
                        wr_stb  <= 1'b1;
                        wr_addr <= ptr;
                        wr_data <= rx;
                        ptr     <= ptr_nx;
                     end
                     default: sda_oe <= 1'b0;
                  endcase
               end else if (in_ack) begin
                  in_ack <= 1'b0;
                  bitcnt <= '0;
                  sda_oe <= 1'b0;
                  case (st)
                     PS_ADDR:
                        if (rw) begin
                           st     <= PS_RDATA;
                           tx     <= rd_data;
                           sda_oe <= !rd_data[7];
                        end else begin
                           st <= PS_PTR;
                        end
                     PS_PTR: st <= PS_WDATA;
                     PS_RDATA: begin
                        ptr <= ptr_nx;
                        if (host_ack) begin
                           tx     <= rd_data;
                           sda_oe <= !rd_data[7];
                        end else begin
                           st <= PS_IGNORE;
                        end
                     end
                     default: ;
                  endcase
               end else if (st == PS_RDATA) begin
                  sda_oe <= !tx[3'(4'd7 - bitcnt)];
               end
            end
         end
      end
   end

   // R9
   idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PS_IDLE || st == PS_IGNORE) |-> !sda_oe);

   // R1
   ignore_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PS_IGNORE) |-> !wr_stb);

   // R2
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> (ptr == AW'(wr_addr + 1'b1)));

   // R10
   sda_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> (!scl_lvl || $past(start_det || stop_det)));
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target #(
   parameter int         NREG        = 16,
   parameter int         NTIME       = 7,
   parameter logic [6:0] DEV_ADDR    = 7'h68,
   parameter int         SYNC_STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    scl_i,
   input  logic                    sda_i,
   output logic                    sda_oe_o,
   input  logic [NREG*8-1:0]       live_regs_i,
   output logic                    wr_stb_o,
   output logic [$clog2(NREG)-1:0] wr_addr_o,
   output logic [7:0]              wr_data_o
);
   localparam int AW = $clog2(NREG);

   if (NREG < 2 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
      $error("NREG must be a power of two of at least 2");
   end
   if (NTIME < 0 || NTIME >= NREG) begin : g_bad_ntime
      $error("NTIME must lie in 0 .. NREG-1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (AW > 8) begin : g_bad_aw
      $error("pointer must fit in one byte");
   end

   logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
   logic snap;
   logic [AW-1:0] rd_addr;
   logic [7:0]    rd_data;

   i2cr_bus_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
   );

   i2cr_proto #(.AW(AW), .DEV_ADDR(DEV_ADDR)) u_proto (
      .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
      .stop_det(stop_det), .rd_data(rd_data), .rd_addr(rd_addr), .snap(snap),
      .sda_oe(sda_oe_o), .wr_stb(wr_stb_o), .wr_addr(wr_addr_o),
      .wr_data(wr_data_o)
   );

   i2cr_readmux #(.NREG(NREG), .NTIME(NTIME)) u_rmux (
      .clk(clk), .rst_n(rst_n), .snap(snap), .live_i(live_regs_i),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );
endmodule

// File: tb/sim_i2c_reg_target.sv
module sim_i2c_reg_target;
   localparam int NREG = 16;
   localparam int NTIME = 7;
   localparam int Q = 10;

   logic clk = 1'b0;
   logic rst_n;
   logic scl_m, sda_m;
   logic sda_oe;
   logic sda_bus;
   logic [NREG*8-1:0] live;
   logic wr_stb;
   logic [3:0] wr_addr;
   logic [7:0] wr_data;
   logic [7:0] mem [NREG];
   logic [7:0] bump;
   int n_chk = 0, n_err = 0, wr_count = 0, viol = 0;
   logic scl_q, oe_q;
   bit finished = 0;

   always #4 clk = ~clk;

   assign sda_bus = sda_m & ~sda_oe;

   i2c_reg_target #(.NREG(NREG), .NTIME(NTIME)) u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
      .sda_oe_o(sda_oe), .live_regs_i(live), .wr_stb_o(wr_stb),
      .wr_addr_o(wr_addr), .wr_data_o(wr_data)
   );

   // register store next to the block: written through the strobe
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) mem[i] <= 8'(8'h30 + i);
      end else if (wr_stb) begin
         mem[wr_addr] <= wr_data;
         wr_count <= wr_count + 1;
      end
   end

   always_comb begin
      for (int i = 0; i < NREG; i++)
         live[i*8 +: 8] = (i < NTIME) ? 8'(mem[i] + bump) : mem[i];
   end

   // R10 monitor: block output moving while SCL stays high
   always @(posedge clk) begin
      scl_q <= scl_m;
      oe_q  <= sda_oe;
      if (rst_n && scl_m && scl_q && sda_oe != oe_q) viol <= viol + 1;
   end

   function automatic logic [7:0] exp_at(input int a, input logic [7:0] b);
      return (a < NTIME) ? 8'(mem[a] + b) : mem[a];
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic q();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
   endtask

   task automatic send(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
      end
      sda_m = 1'b1; q(); scl_m = 1'b1; q(); ack = sda_bus; q(); scl_m = 1'b0; q();
   endtask

   task automatic recv(input logic nack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         q(); scl_m = 1'b1; q(); b[i] = sda_bus; q(); scl_m = 1'b0;
      end
      q(); sda_m = nack; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
      sda_m = 1'b1;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   // stimulus/expected vectors: {address, data}
   localparam logic [11:0] VEC [8] = '{12'h7A5, 12'h83C, 12'hF5A, 12'h0C3,
                                      12'h6FF, 12'h900, 12'hB81, 12'h27E};

   initial begin
      logic ack;
      logic [7:0] b;
      int base;
      scl_m = 1'b1; sda_m = 1'b1; bump = 8'h00; rst_n = 1'b0;
      repeat (5) @(negedge clk);
      chk("R9 reset sda_oe", sda_oe, 0);
      chk("R9 reset wr_stb", wr_stb, 0);
      rst_n = 1'b1;
      q();

      // R2 R4 R8: write one byte, then pointer write + repeated start + read back
      for (int v = 0; v < 8; v++) begin
         bus_start(); send(8'hD0, ack);
         chk("R1 address ack", ack, 0);
         send({4'h0, VEC[v][11:8]}, ack); send(VEC[v][7:0], ack);
         chk("R2 data ack", ack, 0);
         bus_stop();
         bus_start(); send(8'hD0, ack); send({4'h0, VEC[v][11:8]}, ack);
         bus_start(); send(8'hD1, ack); recv(1'b1, b); bus_stop();
         chk("R4 R8 vector readback", b, VEC[v][7:0]);
      end

      // R1: wrong address (and a read to a near address) ignored
      base = wr_count;
      bus_start(); send(8'hA0, ack);
      chk("R1 foreign address nack", ack, 1);
      send(8'h03, ack); send(8'h99, ack);
      chk("R1 ignored byte nack", ack, 1);
      bus_stop();
      chk("R1 no write strobe", wr_count, base);
      bus_start(); send(8'hD3, ack); bus_stop();
      chk("R1 near address nack", ack, 1);

      // R2: multibyte write
      base = wr_count;
      bus_start(); send(8'hD0, ack); send(8'h0C, ack);
      send(8'h11, ack); send(8'h22, ack); send(8'h33, ack); bus_stop();
      chk("R2 reg C", mem[12], 8'h11);
      chk("R2 reg D", mem[13], 8'h22);
      chk("R2 reg E", mem[14], 8'h33);
      chk("R2 strobe count", wr_count - base, 3);

      // R3: write across the top of the space
      bus_start(); send(8'hD0, ack); send(8'h0E, ack);
      send(8'h44, ack); send(8'h55, ack); send(8'h66, ack); bus_stop();
      chk("R3 reg F", mem[15], 8'h55);
      chk("R3 wrapped reg 0", mem[0], 8'h66);

      // R4 R5: pointer-only write, then plain reads resume at the pointer
      bus_start(); send(8'hD0, ack); send(8'h0A, ack); bus_stop();
      bus_start(); send(8'hD1, ack);
      chk("R4 read address ack", ack, 0);
      recv(1'b0, b); chk("R5 first byte at A", b, mem[10]);
      recv(1'b1, b); chk("R4 second byte at B", b, mem[11]);
      chk("R7 released after nack", sda_oe, 0);
      bus_stop();
      chk("R7 SDA high after stop", sda_bus, 1);
      bus_start(); send(8'hD1, ack); recv(1'b1, b); bus_stop();
      chk("R5 resumed at C", b, mem[12]);

      // R6: snapshot at start holds during a multibyte read
      bus_start(); send(8'hD0, ack); send(8'h00, ack); bus_stop();
      bus_start(); send(8'hD1, ack);
      recv(1'b0, b); chk("R6 byte 0", b, exp_at(0, 8'h00));
      bump = 8'h05;
      recv(1'b0, b); chk("R6 byte 1 from snapshot", b, exp_at(1, 8'h00));
      recv(1'b1, b); chk("R6 byte 2 from snapshot", b, exp_at(2, 8'h00));
      bus_stop();
      bus_start(); send(8'hD1, ack); recv(1'b1, b); bus_stop();
      chk("R6 new snapshot at start", b, exp_at(3, 8'h05));

      // R3 R6: pointer wrap on read reloads the snapshot
      bus_start(); send(8'hD0, ack); send(8'h0F, ack); bus_stop();
      bus_start(); send(8'hD1, ack);
      bump = 8'h09;
      recv(1'b0, b); chk("R3 read at F", b, mem[15]);
      recv(1'b1, b); chk("R6 wrap snapshot at 0", b, exp_at(0, 8'h09));
      bus_stop();

      // R8: repeated start in the middle of a write
      bus_start(); send(8'hD0, ack); send(8'h05, ack); send(8'h77, ack);
      bus_start(); send(8'hD1, ack);
      chk("R8 address ack after repeated start", ack, 0);
      recv(1'b1, b); bus_stop();
      chk("R8 write before restart", mem[5], 8'h77);
      chk("R8 read continues at 6", b, exp_at(6, 8'h09));

      q();
      chk("R10 no SDA change while SCL high", viol, 0);
      chk("R9 idle release", sda_oe, 0);

      if (!finished) begin
         finished = 1;
         summary();
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         summary();
         $finish;
      end
   end
endmodule